// File: doc/BRIEF.md
# Palette Entry Format Converter

This block turns raw 32-bit colour-table words, streamed in from memory while a colour-table load is in progress, into uniform entries for a palette RAM. Each entry written out carries 8-bit red, green and blue channels and one transparency flag. The pixel depth selects how many entries a load carries. A two-bit format selector picks the layout of the raw word. A grayscale switch copies the low byte of the word into all three channels, whatever the layout.

A load begins with a one-cycle `load_start` pulse. Words then arrive over a valid/ready handshake. Each accepted word produces one RAM write at the next address. A `done` pulse marks the end of the load. The raw words are also kept in an internal store. When the format selector later changes while no load is running, the block rebuilds the whole palette from those stored words, without a new memory fetch.

Top module: `pal_convert`

## Requirements
- R1: Depth code 1 loads 4 entries, code 2 loads 16 entries and code 3 loads 256 entries. A `load_start` with any other depth code is ignored: `in_ready` stays low, nothing is written and `done` does not pulse.
- R2: Format 0 builds red from word bits 15:11, green from bits 10:5 and blue from bits 4:0. Each field goes to the top of its 8-bit channel, the low bits are filled with zeros, and transparency is 0.
- R3: Format 1 uses the same colour fields as format 0 and takes transparency from word bit 24.
- R4: Format 2 builds red from bits 23:19, green from bits 15:10 and blue from bits 7:3, aligned to the top with zero fill. Transparency comes from bit 24.
- R5: Format 3 builds red from bits 23:16, green from bits 15:8 and blue from bits 7:0. Transparency comes from bit 24.
- R6: When the grayscale switch is set, red, green and blue all equal word bits 7:0 in every format. Transparency still follows the format's rule.
- R7: `in_ready` is high only while a load is running. Every accepted word produces one write on the next cycle. Writes go to addresses 0, 1, 2 and so on, in order of arrival. `pal_wdata` holds {transparency, R[7:0], G[7:0], B[7:0]}, with transparency in bit 24 and red in bits 23:16.
- R8: `done` is a one-cycle pulse, raised in the cycle directly after the final write of a load or a rebuild.
- R9: When the format selector differs from the format of the last completed pass while the block is idle and a palette is held, every entry of the last load is rewritten in address order. The rewrite uses the new format and the grayscale setting present when the rebuild starts, and it ends with `done`.
- R10: After reset `in_ready`, `pal_we` and `done` are low, and no rebuild starts until a load has completed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| load_start | input | 1 | One-cycle pulse that begins a colour-table load |
| cfg_depth | input | DEPTH_W | Pixel depth code (1, 2 or 3 load entries) |
| cfg_fmt | input | 2 | Raw word layout selector |
| cfg_mono | input | 1 | Grayscale switch |
| in_valid | input | 1 | Raw word valid |
| in_data | input | 32 | Raw colour-table word |
| in_ready | output | 1 | Block accepts a raw word |
| pal_we | output | 1 | Palette RAM write enable |
| pal_addr | output | PAL_AW | Palette RAM write address |
| pal_wdata | output | 25 | Entry {transparency, R, G, B} |
| done | output | 1 | End of a load or rebuild |

## Verification
The bench builds the block with its default parameters: an 8-bit palette address and a 4-bit depth code. With these values the full 256-entry load is reachable, so the address runs through its whole range and the entry counter reaches its top bit. Depth codes 0 and 4 are also reachable and exercise the ignored-start path. Random words, spaced by random valid gaps, are mixed with all-ones and all-zero words under all four layouts, with and without grayscale. A change of the format selector after a load then drives the rebuild from the stored words.

// File: rtl/pal_conv_pkg.sv
package pal_conv_pkg;
  localparam int RAW_W   = 25;  // raw bits any layout reads
  localparam int ENTRY_W = 25;

  typedef enum logic [2:0] {
    S_IDLE, S_LOAD, S_REPLAY, S_DRAIN, S_FIN
  } pc_state_e;

  typedef struct packed {
    logic       transp;
    logic [7:0] r;
    logic [7:0] g;
    logic [7:0] b;
  } pal_entry_t;
endpackage

// File: rtl/pal_fmt_decode.sv
module pal_fmt_decode
  import pal_conv_pkg::*;
(
  input  logic [RAW_W-1:0] raw,
  input  logic [1:0]       fmt,
  input  logic             mono,
  output pal_entry_t       ent
);
  always_comb begin
    ent = '0;
    unique case (fmt)
      2'd0: begin
        ent.r = {raw[15:11], 3'b000};
        ent.g = {raw[10:5], 2'b00};
        ent.b = {raw[4:0], 3'b000};
        ent.transp = 1'b0;
      end
      2'd1: begin
        ent.r = {raw[15:11], 3'b000};
        ent.g = {raw[10:5], 2'b00};
        ent.b = {raw[4:0], 3'b000};
        ent.transp = raw[24];
      end
      2'd2: begin
        ent.r = {raw[23:19], 3'b000};
        ent.g = {raw[15:10], 2'b00};
        ent.b = {raw[7:3], 3'b000};
        ent.transp = raw[24];
      end
      default: begin
        ent.r = raw[23:16];
        ent.g = raw[15:8];
        ent.b = raw[7:0];
        ent.transp = raw[24];
      end
    endcase
    if (mono) begin
      ent.r = raw[7:0];
      ent.g = raw[7:0];
      ent.b = raw[7:0];
    end
  end
endmodule

// File: rtl/pal_raw_store.sv
module pal_raw_store #(
  parameter int AW = 8,
  parameter int W  = 25
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  localparam int DEPTH = 1 << AW;

  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/pal_convert.sv
module pal_convert
  import pal_conv_pkg::*;
#(
  parameter int PAL_AW  = 8,
  parameter int DEPTH_W = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               load_start,
  input  logic [DEPTH_W-1:0] cfg_depth,
  input  logic [1:0]         cfg_fmt,
  input  logic               cfg_mono,
  input  logic               in_valid,
  input  logic [31:0]        in_data,
  output logic               in_ready,
  output logic               pal_we,
  output logic [PAL_AW-1:0]  pal_addr,
  output logic [ENTRY_W-1:0] pal_wdata,
  output logic               done
);
  localparam int CNT_W = PAL_AW + 1;

  function automatic logic [CNT_W-1:0] entries_for(input logic [DEPTH_W-1:0] code);
    case (code)
      DEPTH_W'(1): return CNT_W'(4);
      DEPTH_W'(2): return CNT_W'(16);
      DEPTH_W'(3): return CNT_W'(256);
      default:     return '0;
    endcase
  endfunction

  pc_state_e        state;
  logic [CNT_W-1:0] cnt, total, n_loaded;
  logic [1:0]       fmt_q, fmt_seen;
  logic             mono_q;
  logic             rd_v;
  logic [PAL_AW-1:0] rd_a;
  logic [RAW_W-1:0] raw_q, dec_src;
  pal_entry_t       ent;
  logic             accept, rd_req;
  logic [CNT_W-1:0] start_cnt;
  logic             unused_hi;

  assign unused_hi = ^in_data[31:RAW_W];
  assign in_ready  = (state == S_LOAD);
  assign accept    = in_valid && in_ready;
  assign rd_req    = (state == S_REPLAY);
  assign start_cnt = entries_for(cfg_depth);
  assign dec_src   = rd_v ? raw_q : in_data[RAW_W-1:0];

  pal_raw_store #(.AW(PAL_AW), .W(RAW_W)) u_store (
    .clk   (clk),
    .we    (accept),
    .waddr (cnt[PAL_AW-1:0]),
    .wdata (in_data[RAW_W-1:0]),
    .re    (rd_req),
    .raddr (cnt[PAL_AW-1:0]),
    .rdata (raw_q)
  );

  pal_fmt_decode u_dec (
    .raw  (dec_src),
    .fmt  (fmt_q),
    .mono (mono_q),
    .ent  (ent)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= S_IDLE;
      cnt       <= '0;
      total     <= '0;
      n_loaded  <= '0;
      fmt_q     <= '0;
      fmt_seen  <= '0;
      mono_q    <= 1'b0;
      rd_v      <= 1'b0;
      rd_a      <= '0;
      pal_we    <= 1'b0;
      pal_addr  <= '0;
      pal_wdata <= '0;
      done      <= 1'b0;
    end else begin
      pal_we <= 1'b0;
      done   <= 1'b0;
      rd_v   <= 1'b0;
      if (accept) begin
        pal_we    <= 1'b1;
        pal_addr  <= cnt[PAL_AW-1:0];
        pal_wdata <= ent;
      end else if (rd_v) begin
        pal_we    <= 1'b1;
        pal_addr  <= rd_a;
        pal_wdata <= ent;
      end
      case (state)
        S_IDLE: begin
          if (load_start && start_cnt != '0) begin
            state  <= S_LOAD;
            total  <= start_cnt;
            cnt    <= '0;
            fmt_q  <= cfg_fmt;
            mono_q <= cfg_mono;
          end else if (cfg_fmt != fmt_seen && n_loaded != '0) begin
            state  <= S_REPLAY;
            total  <= n_loaded;
            cnt    <= '0;
            fmt_q  <= cfg_fmt;
            mono_q <= cfg_mono;
          end
        end
        S_LOAD: begin
          if (accept) begin
            cnt <= cnt + 1'b1;
            if (cnt == total - 1'b1) begin
              state    <= S_FIN;
              n_loaded <= total;
            end
          end
        end
        S_REPLAY: begin
          rd_v <= 1'b1;
          rd_a <= cnt[PAL_AW-1:0];
          cnt  <= cnt + 1'b1;
          if (cnt == total - 1'b1) state <= S_DRAIN;
        end
        S_DRAIN: state <= S_FIN;
        S_FIN: begin
          done     <= 1'b1;
          fmt_seen <= fmt_q;
          state    <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pal_convert_chk.sv
module pal_convert_chk (
  input logic        clk,
  input logic        rst,
  input logic        in_valid,
  input logic        in_ready,
  input logic        pal_we,
  input logic [24:0] pal_wdata,
  input logic        done,
  input logic [1:0]  fmt_q,
  input logic        mono_q
);
  p_accept_writes_r7: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=> pal_we);

  p_done_after_write_r8: assert property (@(posedge clk) disable iff (rst)
    done |-> $past(pal_we));

  p_done_single_r8: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  p_fmt0_opaque_r2: assert property (@(posedge clk) disable iff (rst)
    (pal_we && fmt_q == 2'd0) |-> !pal_wdata[24]);

  p_mono_equal_r6: assert property (@(posedge clk) disable iff (rst)
    (pal_we && mono_q) |-> (pal_wdata[23:16] == pal_wdata[15:8] &&
                            pal_wdata[15:8] == pal_wdata[7:0]));
endmodule

bind pal_convert pal_convert_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .pal_we    (pal_we),
  .pal_wdata (pal_wdata),
  .done      (done),
  .fmt_q     (fmt_q),
  .mono_q    (mono_q)
);

// File: tb/sim_pal_convert.sv
module sim_pal_convert;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        load_start = 1'b0;
  logic [3:0]  cfg_depth = '0;
  logic [1:0]  cfg_fmt = '0;
  logic        cfg_mono = 1'b0;
  logic        in_valid = 1'b0;
  logic [31:0] in_data = '0;
  logic        in_ready, pal_we, done;
  logic [7:0]  pal_addr;
  logic [24:0] pal_wdata;

  int n_chk = 0, n_err = 0;
  int wr_cnt = 0, done_cnt = 0, order_err = 0, late_done = 0, ready_cnt = 0;
  logic [24:0] wr_mem [256];
  logic [31:0] words [256];
  logic prev_we = 1'b0;

  always #5 clk = ~clk;

  pal_convert u0 (
    .clk(clk), .rst(rst), .load_start(load_start), .cfg_depth(cfg_depth),
    .cfg_fmt(cfg_fmt), .cfg_mono(cfg_mono), .in_valid(in_valid),
    .in_data(in_data), .in_ready(in_ready), .pal_we(pal_we),
    .pal_addr(pal_addr), .pal_wdata(pal_wdata), .done(done)
  );

  always @(negedge clk) begin
    if (!rst) begin
      if (pal_we) begin
        if (int'(pal_addr) != wr_cnt) order_err++;
        wr_mem[pal_addr] = pal_wdata;
        wr_cnt++;
      end
      if (done) begin
        done_cnt++;
        if (!prev_we) late_done++;
      end
      if (in_ready) ready_cnt++;
      prev_we = pal_we;
    end
  end

  function automatic logic [24:0] exp_conv(input logic [31:0] w, input int fmt, input bit mono);
    logic [7:0] r, g, b;
    logic t;
    case (fmt)
      0: begin r = {w[15:11], 3'b0}; g = {w[10:5], 2'b0}; b = {w[4:0], 3'b0}; t = 1'b0; end
      1: begin r = {w[15:11], 3'b0}; g = {w[10:5], 2'b0}; b = {w[4:0], 3'b0}; t = w[24]; end
      2: begin r = {w[23:19], 3'b0}; g = {w[15:10], 2'b0}; b = {w[7:3], 3'b0}; t = w[24]; end
      default: begin r = w[23:16]; g = w[15:8]; b = w[7:0]; t = w[24]; end
    endcase
    if (mono) begin r = w[7:0]; g = w[7:0]; b = w[7:0]; end
    return {t, r, g, b};
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic clear_mon();
    wr_cnt = 0; done_cnt = 0; order_err = 0; late_done = 0; ready_cnt = 0;
  endtask

  task automatic fill_words(input int n);
    for (int i = 0; i < n; i++) words[i] = $urandom;
    words[0] = 32'hFFFF_FFFF;
    if (n > 1) words[1] = 32'h0000_0000;
    if (n > 2) words[2] = 32'h0100_F81F;
  endtask

  task automatic wait_done();
    int t = 0;
    while (done_cnt == 0 && t < 2000) begin @(posedge clk); t++; end
    repeat (3) @(posedge clk);
    #1;
  endtask

  task automatic verify(input int n, input int fmt, input bit mono, input string req);
    int bad = 0;
    check(wr_cnt == n, req, "write count", wr_cnt, n);
    for (int i = 0; i < n; i++) begin
      logic [24:0] e;
      e = exp_conv(words[i], fmt, mono);
      if (wr_mem[i] !== e) begin
        bad++;
        if (bad == 1) check(1'b0, req, "entry value", wr_mem[i], e);
      end
    end
    if (bad == 0) check(1'b1, req, "entry value", 0, 0);
    check(order_err == 0, "R7", "address order errors", order_err, 0);
    check(done_cnt == 1, "R8", "done pulses", done_cnt, 1);
    check(late_done == 0, "R8", "done not after final write", late_done, 0);
  endtask

  task automatic do_load(input int depth, input int fmt, input bit mono, input int n,
                         input string req);
    clear_mon();
    fill_words(n);
    @(posedge clk); #1;
    cfg_depth = depth[3:0]; cfg_fmt = fmt[1:0]; cfg_mono = mono; load_start = 1'b1;
    @(posedge clk); #1;
    load_start = 1'b0;
    for (int i = 0; i < n; i++) begin
      repeat ($urandom % 3) begin @(posedge clk); #1; end
      in_valid = 1'b1; in_data = words[i];
      @(posedge clk); #1;
      in_valid = 1'b0;
    end
    wait_done();
    verify(n, fmt, mono, req);
  endtask

  task automatic bad_depth(input int depth);
    clear_mon();
    @(posedge clk); #1;
    cfg_depth = depth[3:0]; load_start = 1'b1; in_valid = 1'b1; in_data = 32'h1234_5678;
    @(posedge clk); #1;
    load_start = 1'b0;
    repeat (6) @(posedge clk);
    #1; in_valid = 1'b0;
    check(ready_cnt == 0, "R1", "ready on bad depth", ready_cnt, 0);
    check(wr_cnt == 0, "R1", "writes on bad depth", wr_cnt, 0);
    check(done_cnt == 0, "R1", "done on bad depth", done_cnt, 0);
  endtask

  task automatic do_replay(input int fmt, input bit mono, input int n, input string req);
    clear_mon();
    @(posedge clk); #1;
    cfg_fmt = fmt[1:0]; cfg_mono = mono;
    wait_done();
    check(ready_cnt == 0, "R9", "ready during rebuild", ready_cnt, 0);
    verify(n, fmt, mono, req);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
    $finish;
  end

  initial begin : main
    void'($urandom(32'd7));
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    check(!in_ready, "R10", "in_ready after reset", in_ready, 0);
    check(!pal_we, "R10", "pal_we after reset", pal_we, 0);
    check(!done, "R10", "done after reset", done, 0);
    clear_mon();
    @(posedge clk); #1 cfg_fmt = 2'd2;
    repeat (5) @(posedge clk);
    #1;
    check(wr_cnt == 0 && done_cnt == 0, "R10", "rebuild before any load", wr_cnt, 0);
    cfg_fmt = 2'd0;

    do_load(1, 0, 1'b0, 4, "R2");
    do_load(2, 1, 1'b0, 16, "R3");
    do_load(3, 2, 1'b0, 256, "R4");
    do_load(1, 3, 1'b0, 4, "R5");
    do_load(2, 3, 1'b1, 16, "R6");
    do_load(2, 0, 1'b1, 16, "R6");
    do_load(3, 1, 1'b0, 256, "R1");
    bad_depth(0);
    bad_depth(4);
    do_load(1, 0, 1'b0, 4, "R1");
    do_replay(3, 1'b0, 4, "R9");
    do_replay(2, 1'b1, 4, "R9");
    do_replay(1, 1'b0, 4, "R9");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
    $finish;
  end
endmodule